// File: doc/BRIEF.md
# Four-Channel DAC Input Latch Bank

This block is a clocked model of the digital input stage of a four-channel, parallel-loaded digital-to-analog converter. A fast system clock samples three inputs: an active-low write strobe, a two-bit channel select and an 8-bit code bus. All three pass through a two-flop synchronizer. The block keeps four 8-bit channel codes. While the strobe is low, the selected channel follows the bus. When the strobe returns high, that channel keeps the last code it followed.

The block also checks the timing of each write cycle, counted in synchronized clock samples. It has three separate sticky flags: one for a strobe low period that is too short, one for data that changed too close before the strobe rose, and one for data that changed too soon after it. A synchronous clear input resets the flags. A monitor output gives the ideal unipolar output voltage, in millivolts, of one selected channel for a 10 V full scale.

Top module: `quad_dac_latch_bank`

## Requirements
- R1: A synchronous reset sets all four channel codes to 0, clears all three error flags and drives the monitor output to 0.
- R2: While the synchronized strobe is high, no channel code changes, whatever values the select and code inputs take.
- R3: While the strobe is low, the selected channel follows the code bus. A change at the inputs reaches `codes_o` three clock edges later (two synchronizer stages, then the channel register).
- R4: The channel select value picks the slice of `codes_o`: 0 selects bits 7:0, 1 selects bits 15:8, 2 selects bits 23:16 and 3 selects bits 31:24.
- R5: When the strobe rises, the selected channel keeps the code it held in the last low sample. Later changes on the bus while the strobe is high do not alter it.
- R6: If the select value changes while the strobe is low, the newly selected channel starts to follow the bus. The previously selected channel keeps the last code it followed.
- R7: `err_width_o` sets when the strobe rises after fewer than `PW_CYC` low samples.
- R8: `err_setup_o` sets when the code bus changed in any of the last `SETUP_CYC` samples up to and including the sample in which the strobe is seen high again.
- R9: `err_hold_o` sets when the code bus changes in any of the `HOLD_CYC` samples that follow the sample in which the strobe rose.
- R10: Each error flag stays set until `clr_err_i` is high at a clock edge. A violation detected in that same cycle sets its flag again. Each flag responds only to its own rule.
- R11: `mon_mv_o` equals floor(code × 10000 / 256) for the channel selected by `mon_sel_i`. Examples: code 255 gives 9960, code 128 gives 5000, code 1 gives 39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err_i | input | 1 | Synchronous clear of the three error flags |
| wr_n_i | input | 1 | Asynchronous active-low write strobe |
| sel_i | input | 2 | Channel select for writes |
| code_i | input | 8 | Code bus |
| mon_sel_i | input | 2 | Channel shown on the monitor output |
| codes_o | output | 32 | Four channel codes; channel n sits in bits 8n+7:8n |
| mon_mv_o | output | 14 | Ideal output of the monitored channel, in millivolts |
| err_width_o | output | 1 | Sticky flag: strobe low period too short |
| err_setup_o | output | 1 | Sticky flag: code changed too close before the strobe rose |
| err_hold_o | output | 1 | Sticky flag: code changed too soon after the strobe rose |

## Verification
The bench moves the select value while the strobe is low. A design that let the old channel keep following the bus, or that reset the old channel, would show a wrong code in the slice it left. It drives the select and code inputs hard while the strobe is high, which catches a latch that loads whenever the code changes. It changes the bus right after a clean write, which catches a capture taken one sample late. Each timing rule is broken on its own, so a flag wired to the wrong rule, a flag that does not stay set, or a clear that does not work shows up as a wrong flag value.

// File: rtl/qdl_pkg.sv
package qdl_pkg;

    localparam int CODE_W  = 8;
    localparam int CH_NUM  = 4;
    localparam int SEL_W   = $clog2(CH_NUM);
    localparam int FULL_MV = 10000;
    localparam int MV_W    = 14;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic             strobe_n;
        logic [SEL_W-1:0] sel;
        code_t            code;
    } bus_t;

    localparam bus_t BUS_IDLE = '{strobe_n: 1'b1, sel: '0, code: '0};

    function automatic logic [MV_W-1:0] code_to_mv(input code_t c);
        int unsigned prod;
        prod = int'(c) * FULL_MV;
        return MV_W'(prod >> CODE_W);
    endfunction

endpackage

// File: rtl/qdl_in_sync.sv
module qdl_in_sync
    import qdl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  bus_t bus_i,
    output bus_t bus_o
);

    bus_t stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= BUS_IDLE;
        end else begin
            stg_q[0] <= bus_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign bus_o = stg_q[STAGES-1];

endmodule

// File: rtl/qdl_chan_bank.sv
module qdl_chan_bank
    import qdl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  bus_t  bus_s,
    output code_t chan_o [CH_NUM]
);

    code_t chan_q [CH_NUM];

    for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
        logic hit;
        assign hit = !bus_s.strobe_n && (bus_s.sel == SEL_W'(i));

        always_ff @(posedge clk) begin
            if (rst)      chan_q[i] <= '0;
            else if (hit) chan_q[i] <= bus_s.code;
        end

        assign chan_o[i] = chan_q[i];

        // R2
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            bus_s.strobe_n |=> $stable(chan_q[i]));

        // R3
        follow_chk: assert property (@(posedge clk) disable iff (rst)
            (!bus_s.strobe_n && bus_s.sel == SEL_W'(i)) |=> chan_q[i] == $past(bus_s.code));

        // R6
        other_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (!bus_s.strobe_n && bus_s.sel != SEL_W'(i)) |=> $stable(chan_q[i]));
    end

endmodule

// File: rtl/qdl_wr_timing.sv
module qdl_wr_timing
    import qdl_pkg::*;
#(
    parameter int PW_CYC    = 5,
    parameter int SETUP_CYC = 7,
    parameter int HOLD_CYC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  bus_t bus_s,
    output logic err_width,
    output logic err_setup,
    output logic err_hold
);

    localparam int PW_W = $clog2(PW_CYC + 2);
    localparam int SU_W = $clog2(SETUP_CYC + 2);
    localparam int HD_W = $clog2(HOLD_CYC + 2);

    logic            strobe_d;
    code_t           code_d;
    logic [PW_W-1:0] low_cnt;
    logic [SU_W-1:0] stab_cnt;
    logic [HD_W-1:0] hold_cnt;
    logic            rise, chg;
    logic            v_width, v_setup, v_hold;

    assign rise = bus_s.strobe_n && !strobe_d;
    assign chg  = bus_s.code != code_d;

    assign v_width = rise && (low_cnt < PW_W'(PW_CYC));
    assign v_setup = rise && (chg || (stab_cnt < SU_W'(SETUP_CYC)));
    assign v_hold  = !rise && (hold_cnt != '0) && chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b1;
            code_d   <= '0;
            low_cnt  <= '0;
            stab_cnt <= '0;
            hold_cnt <= '0;
        end else begin
            strobe_d <= bus_s.strobe_n;
            code_d   <= bus_s.code;
            if (bus_s.strobe_n)                low_cnt <= '0;
            else if (low_cnt != PW_W'(PW_CYC)) low_cnt <= low_cnt + 1'b1;
            if (chg)                               stab_cnt <= '0;
            else if (stab_cnt != SU_W'(SETUP_CYC)) stab_cnt <= stab_cnt + 1'b1;
            if (rise)                 hold_cnt <= HD_W'(HOLD_CYC);
            else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_width <= 1'b0;
            err_setup <= 1'b0;
            err_hold  <= 1'b0;
        end else begin
            err_width <= (err_width && !clr) || v_width;
            err_setup <= (err_setup && !clr) || v_setup;
            err_hold  <= (err_hold  && !clr) || v_hold;
        end
    end

    // R10
    width_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_width && !clr) |=> err_width);

    // R10
    setup_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_setup && !clr) |=> err_setup);

    // R10
    hold_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_hold && !clr) |=> err_hold);

    // R7
    width_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!err_width && !rise) |=> !err_width);

endmodule

// File: rtl/quad_dac_latch_bank.sv
module quad_dac_latch_bank
    import qdl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PW_CYC      = 5,
    parameter int SETUP_CYC   = 7,
    parameter int HOLD_CYC    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_err_i,
    input  logic                     wr_n_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic [CODE_W-1:0]        code_i,
    input  logic [SEL_W-1:0]         mon_sel_i,
    output logic [CH_NUM*CODE_W-1:0] codes_o,
    output logic [MV_W-1:0]          mon_mv_o,
    output logic                     err_width_o,
    output logic                     err_setup_o,
    output logic                     err_hold_o
);

    bus_t  bus_raw, bus_s;
    code_t chan [CH_NUM];

    assign bus_raw = '{strobe_n: wr_n_i, sel: sel_i, code: code_i};

    qdl_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .bus_i (bus_raw),
        .bus_o (bus_s)
    );

    qdl_chan_bank i_bank (
        .clk    (clk),
        .rst    (rst),
        .bus_s  (bus_s),
        .chan_o (chan)
    );

    qdl_wr_timing #(
        .PW_CYC    (PW_CYC),
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) i_timing (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_err_i),
        .bus_s     (bus_s),
        .err_width (err_width_o),
        .err_setup (err_setup_o),
        .err_hold  (err_hold_o)
    );

    for (genvar i = 0; i < CH_NUM; i++) begin : g_pack
        assign codes_o[i*CODE_W +: CODE_W] = chan[i];
    end

    assign mon_mv_o = code_to_mv(chan[mon_sel_i]);

    // R11
    always_comb begin
        if (!rst) mon_full_chk: assert (mon_mv_o < MV_W'(FULL_MV));
    end

endmodule

// File: tb/test_quad_dac_latch_bank.sv
module test_quad_dac_latch_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_err_i = 1'b0;
    logic        wr_n_i = 1'b1;
    logic [1:0]  sel_i = '0;
    logic [7:0]  code_i = '0;
    logic [1:0]  mon_sel_i = '0;
    logic [31:0] codes_o;
    logic [13:0] mon_mv_o;
    logic        err_width_o, err_setup_o, err_hold_o;

    int checks = 0;
    int errors = 0;

    always #5ns clk = ~clk;

    quad_dac_latch_bank i_quad_dac_latch_bank (
        .clk         (clk),
        .rst         (rst),
        .clr_err_i   (clr_err_i),
        .wr_n_i      (wr_n_i),
        .sel_i       (sel_i),
        .code_i      (code_i),
        .mon_sel_i   (mon_sel_i),
        .codes_o     (codes_o),
        .mon_mv_o    (mon_mv_o),
        .err_width_o (err_width_o),
        .err_setup_o (err_setup_o),
        .err_hold_o  (err_hold_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ch(input logic [1:0] ch, input logic [7:0] val);
        @(negedge clk);
        sel_i = ch; code_i = val;
        idle(10);
        wr_n_i = 1'b0;
        idle(10);
        wr_n_i = 1'b1;
        idle(12);
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_err_i = 1'b1;
        @(negedge clk); clr_err_i = 1'b0;
        idle(2);
    endtask

    task automatic t_reset();
        idle(6);
        check("R1 codes", codes_o, 32'h0);
        check("R1 flags", {err_width_o, err_setup_o, err_hold_o}, 3'b000);
        check("R1 monitor", mon_mv_o, 14'd0);
    endtask

    task automatic t_addressing();
        write_ch(2'd0, 8'h5A);
        write_ch(2'd1, 8'hC3);
        write_ch(2'd2, 8'hFF);
        write_ch(2'd3, 8'h01);
        check("R4 slice map", codes_o, 32'h01FFC35A);
        check("R3 clean writes raise no flag", {err_width_o, err_setup_o, err_hold_o}, 3'b000);
        mon_sel_i = 2'd2; #1;
        check("R11 full scale", mon_mv_o, 14'd9960);
        mon_sel_i = 2'd0; #1;
        check("R11 code 0x5A", mon_mv_o, 14'd3515);
        mon_sel_i = 2'd3; #1;
        check("R11 one lsb", mon_mv_o, 14'd39);
    endtask

    task automatic t_idle_ignored();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sel_i = 2'(k); code_i = 8'(k * 37 + 11);
        end
        idle(6);
        check("R2 strobe high ignores bus", codes_o, 32'h01FFC35A);
    endtask

    task automatic t_follow_and_hold();
        @(negedge clk);
        sel_i = 2'd1; code_i = 8'h10;
        idle(10);
        wr_n_i = 1'b0;
        idle(5);
        check("R3 follows first value", codes_o[15:8], 8'h10);
        code_i = 8'h20;
        idle(4);
        check("R3 follows second value", codes_o[15:8], 8'h20);
        idle(8);
        wr_n_i = 1'b1;
        idle(12);
        code_i = 8'hEE;
        idle(6);
        check("R5 value held after rise", codes_o[15:8], 8'h20);
        check("R5 no flag on clean cycle", {err_width_o, err_setup_o, err_hold_o}, 3'b000);
        mon_sel_i = 2'd1; #1;
        check("R11 monitor follows held code", mon_mv_o, 14'd1250);
    endtask

    task automatic t_sel_switch();
        @(negedge clk);
        sel_i = 2'd0; code_i = 8'h33;
        idle(10);
        wr_n_i = 1'b0;
        idle(10);
        sel_i = 2'd2; code_i = 8'h80;
        idle(12);
        wr_n_i = 1'b1;
        idle(12);
        check("R6 old channel kept", codes_o[7:0], 8'h33);
        check("R6 new channel loaded", codes_o[23:16], 8'h80);
        check("R6 other channels kept", {codes_o[31:24], codes_o[15:8]}, 16'h0120);
        mon_sel_i = 2'd2; #1;
        check("R11 half scale", mon_mv_o, 14'd5000);
    endtask

    task automatic t_width();
        @(negedge clk);
        sel_i = 2'd3; code_i = 8'h01;
        idle(10);
        wr_n_i = 1'b0;
        idle(2);
        wr_n_i = 1'b1;
        idle(12);
        check("R7 short strobe flagged alone", {err_width_o, err_setup_o, err_hold_o}, 3'b100);
        write_ch(2'd3, 8'h01);
        check("R10 width flag sticky", err_width_o, 1'b1);
        clear_flags();
        check("R10 clear resets width flag", {err_width_o, err_setup_o, err_hold_o}, 3'b000);
    endtask

    task automatic t_setup();
        @(negedge clk);
        sel_i = 2'd0; code_i = 8'h40;
        idle(10);
        wr_n_i = 1'b0;
        idle(10);
        code_i = 8'h41;
        idle(2);
        wr_n_i = 1'b1;
        idle(12);
        check("R8 late data flagged alone", {err_width_o, err_setup_o, err_hold_o}, 3'b010);
        clear_flags();
        check("R10 clear resets setup flag", err_setup_o, 1'b0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        sel_i = 2'd0; code_i = 8'h50;
        idle(10);
        wr_n_i = 1'b0;
        idle(10);
        wr_n_i = 1'b1;
        idle(1);
        code_i = 8'h51;
        idle(12);
        check("R9 early change flagged alone", {err_width_o, err_setup_o, err_hold_o}, 3'b001);
        check("R5 capture before hold change", codes_o[7:0], 8'h50);
        clear_flags();
        check("R10 clear resets hold flag", err_hold_o, 1'b0);
    endtask

    initial begin
        #2_000_000ns;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_addressing();
        t_idle_ignored();
        t_follow_and_hold();
        t_sel_switch();
        t_width();
        t_setup();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule